// File: doc/BRIEF.md
# Two-Digit Multiplexed Display Scanner with Dimming

This block time-multiplexes a two-digit fluorescent display. A free-running oscillator counter splits each frame into two equal phases. During each phase the block presents that digit's 37 segment bits on the segment outputs and drives that digit's enable high. The digit enable goes low a fixed guard time before the segments switch, and after the switch it stays low for an off-time. The 10-bit brightness value sets the off-time, so larger values keep the digit lit for longer.

Two sources can supply the brightness. In digital mode it comes straight from a latched 10-bit value. In analog mode it comes from a 6-bit converter code, which a built-in curve expands to 10 bits. An active-low blank input switches both digits off without disturbing the scan or the segment outputs. The serial loader, the converter and the high-voltage drivers are outside this block.

Top module: `digit_scanner`

## Requirements
- R1: A 12-bit counter advances once per clock. Counter bit 11 selects the phase: 0 for digit 0 and 1 for digit 1. Each phase therefore lasts 2048 clocks and a frame lasts 4096 clocks. The position within a phase is counter bits 10:0.
- R2: Output `seg[i]` equals `seg_data[i]` throughout phase 0 and `seg_data[i+37]` throughout phase 1. `seg` does not depend on `blank_n`.
- R3: Both digit enables are low at phase positions 2046 and 2047. This is the guard before each segment change.
- R4: Let D be the effective brightness value. The current phase's enable is high exactly when the position p satisfies rise <= p < 2046, where rise = max(2, 2*(1023-D)). With D = 1023 or 1022 the enable rises at position 2. With D = 0 it never rises.
- R5: While `blank_n` is 0, both `digit` bits are 0.
- R6: When `analog_mode` is 1, D = {code, code[5:2]}, where code is `dim_code`, and `dim_val` has no effect. When `analog_mode` is 0, D = `dim_val`.
- R7: At most one `digit` bit is high at any time. `digit[0]` is high only in phase 0 and `digit[1]` only in phase 1.
- R8: While `rst_n` is 0, the counter is held at 0, which is phase 0, position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset of the scan counter |
| seg_data | input | 74 | Latched segment bits: [36:0] for digit 0, [73:37] for digit 1 |
| dim_val | input | 10 | Latched digital brightness value |
| analog_mode | input | 1 | 1 selects the expanded converter code as brightness |
| blank_n | input | 1 | Active-low display blank |
| dim_code | input | 6 | Converter code used in analog mode |
| digit | output | 2 | Digit enables, bit 0 for digit 0 |
| seg | output | 37 | Segment outputs for the current phase |

## Verification
The assertions assume that `seg_data`, `dim_val`, `dim_code` and `analog_mode` only change as latched register values, so each one holds steady over many clocks. They also assume that `blank_n` is a level input and does not glitch within a clock. The stimulus changes these inputs only at falling clock edges and then holds them while the counter runs to the position under test. Guard-window and phase-wrap checks are therefore taken against a settled brightness value.

// File: rtl/digit_scanner.sv
`timescale 1ns/1ps
module digit_scanner #(
  parameter int SEG_N  = 37,
  parameter int DIM_W  = 10,
  parameter int CODE_W = 6,
  parameter int PH_W   = 11,
  parameter int GUARD  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*SEG_N-1:0] seg_data,
  input  logic [DIM_W-1:0]   dim_val,
  input  logic               analog_mode,
  input  logic               blank_n,
  input  logic [CODE_W-1:0]  dim_code,
  output logic [1:0]         digit,
  output logic [SEG_N-1:0]   seg
);
  localparam int SHIFT = PH_W - DIM_W;
  localparam int PHASE = 1 << PH_W;
  localparam logic [DIM_W-1:0] DMAX    = '1;
  localparam logic [PH_W:0]    GUARD_V = (PH_W+1)'(GUARD);
  localparam logic [PH_W:0]    LIMIT   = (PH_W+1)'(PHASE - GUARD);
  localparam logic [PH_W-1:0]  LAST    = '1;

  logic [PH_W:0]       cnt;
  logic                phase;
  logic [PH_W-1:0]     pos;
  logic [DIM_W-1:0]    expanded, eff;
  logic [PH_W:0]       off_raw, rise;
  logic                lit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;

  assign phase = cnt[PH_W];
  assign pos   = cnt[PH_W-1:0];

  for (genvar j = 0; j < DIM_W; j++) begin : g_expand
    assign expanded[DIM_W-1-j] = dim_code[CODE_W-1-(j % CODE_W)];
  end

  assign eff     = analog_mode ? expanded : dim_val;
  assign off_raw = {{(PH_W+1-DIM_W){1'b0}}, DMAX - eff} << SHIFT;
  assign rise    = (off_raw < GUARD_V) ? GUARD_V : off_raw;
  assign lit     = blank_n && ({1'b0, pos} >= rise) && ({1'b0, pos} < LIMIT);
  assign digit   = lit ? (phase ? 2'b10 : 2'b01) : 2'b00;
  assign seg     = phase ? seg_data[2*SEG_N-1:SEG_N] : seg_data[SEG_N-1:0];

  // R1
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == LAST) |=> (pos == '0 && phase != $past(phase)));
  // R3
  guard_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, pos} >= LIMIT) |-> (digit == 2'b00));
  // R4
  late_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|digit) |-> ({1'b0, pos} >= GUARD_V));
  // R5
  blank_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |-> (digit == 2'b00));
  // R7
  one_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(digit) && !(digit[0] && phase) && !(digit[1] && !phase));
endmodule

// File: tb/digit_scanner_tb.sv
`timescale 1ns/1ps
module digit_scanner_tb;
  logic        clk = 0, rst_n = 0;
  logic [73:0] seg_data = '0;
  logic [9:0]  dim_val = '0;
  logic        analog_mode = 0, blank_n = 1;
  logic [5:0]  dim_code = '0;
  logic [1:0]  digit;
  logic [36:0] seg;
  logic [11:0] tcnt;
  int checks = 0, fails = 0;

  digit_scanner u_dut (.clk(clk), .rst_n(rst_n), .seg_data(seg_data), .dim_val(dim_val),
    .analog_mode(analog_mode), .blank_n(blank_n), .dim_code(dim_code),
    .digit(digit), .seg(seg));

  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) tcnt <= '0;
    else        tcnt <= tcnt + 1'b1;

  // {analog, dim_val, code, blank_n, position, expected digit}
  localparam int NV = 22;
  localparam logic [31:0] VEC [NV] = '{
    {1'b0, 10'h3FF, 6'd0,  1'b1, 12'd1,    2'b00},  // R4 before rise
    {1'b0, 10'h3FF, 6'd0,  1'b1, 12'd2,    2'b01},  // R4 rise at 2
    {1'b0, 10'h3FF, 6'd0,  1'b1, 12'd2045, 2'b01},  // R4 last lit
    {1'b0, 10'h3FF, 6'd0,  1'b1, 12'd2046, 2'b00},  // R3 guard
    {1'b0, 10'h3FF, 6'd0,  1'b1, 12'd2047, 2'b00},  // R3 guard
    {1'b0, 10'h3FF, 6'd0,  1'b1, 12'd2050, 2'b10},  // R7 phase 1
    {1'b0, 10'h3FF, 6'd0,  1'b1, 12'd4095, 2'b00},  // R3 guard phase 1
    {1'b0, 10'h3FE, 6'd0,  1'b1, 12'd1,    2'b00},  // R4
    {1'b0, 10'h3FE, 6'd0,  1'b1, 12'd2,    2'b01},  // R4 3FE rise at guard
    {1'b0, 10'h0FF, 6'd0,  1'b1, 12'd1535, 2'b00},  // R4
    {1'b0, 10'h0FF, 6'd0,  1'b1, 12'd1536, 2'b01},  // R4
    {1'b0, 10'h0FF, 6'd0,  1'b1, 12'd3583, 2'b00},  // R4
    {1'b0, 10'h0FF, 6'd0,  1'b1, 12'd3584, 2'b10},  // R4
    {1'b0, 10'h001, 6'd0,  1'b1, 12'd2043, 2'b00},  // R4
    {1'b0, 10'h001, 6'd0,  1'b1, 12'd2044, 2'b01},  // R4
    {1'b0, 10'h000, 6'd0,  1'b1, 12'd2045, 2'b00},  // R4 never lit
    {1'b0, 10'h3FF, 6'd0,  1'b0, 12'd1000, 2'b00},  // R5
    {1'b0, 10'h3FF, 6'd0,  1'b0, 12'd3000, 2'b00},  // R5
    {1'b1, 10'h000, 6'd63, 1'b1, 12'd2,    2'b01},  // R6 code 63 -> 3FF
    {1'b1, 10'h3FF, 6'd16, 1'b1, 12'd3573, 2'b00},  // R6 code 16 -> 104h
    {1'b1, 10'h3FF, 6'd16, 1'b1, 12'd3574, 2'b10},  // R6
    {1'b1, 10'h3FF, 6'd0,  1'b1, 12'd2045, 2'b00}   // R6 code 0, dim_val ignored
  };

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at pos %0d", req, act, exp, tcnt);
    end
  endtask

  task automatic goto(input logic [11:0] t);
    while (tcnt != t) @(negedge clk);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    seg_data = {37'h0A5A5A5A5A, 37'h1234567890};
    dim_val  = 10'h3FF;
    repeat (3) @(negedge clk);
    // R8 reset holds phase 0, position 0
    check(64'(digit), 64'(2'b00), "R8 digit in reset");
    check(64'(seg), 64'(seg_data[36:0]), "R8 seg in reset");
    rst_n = 1;
    goto(12'd2);
    check(64'(digit), 64'(2'b01), "R8 first rise after reset");

    for (int i = 0; i < NV; i++) begin
      {analog_mode, dim_val, dim_code, blank_n} = VEC[i][31:14];
      goto(VEC[i][13:2]);
      check(64'(digit), 64'(VEC[i][1:0]), $sformatf("R4/R5/R6 vector %0d", i));
      check(64'($countones(digit) <= 1), 64'd1, "R7 one digit");
    end

    analog_mode = 0; dim_val = 10'h3FF; blank_n = 1;
    goto(12'd5);
    check(64'(seg), 64'(seg_data[36:0]), "R2 phase 0 start");
    goto(12'd2047);
    check(64'(seg), 64'(seg_data[36:0]), "R2 phase 0 end");
    goto(12'd2048);
    check(64'(seg), 64'(seg_data[73:37]), "R2 phase 1 start");
    check(64'(digit), 64'(2'b00), "R1 phase 1 pos 0 dark");
    blank_n = 0;
    goto(12'd3000);
    check(64'(seg), 64'(seg_data[73:37]), "R2 seg not blanked");
    goto(12'd4095);
    check(64'(seg), 64'(seg_data[73:37]), "R1 phase 1 end");
    goto(12'd0);
    check(64'(seg), 64'(seg_data[36:0]), "R1 wrap to phase 0");
    blank_n = 1;
    seg_data = {37'h1FFFFFFFFF, 37'h0};
    goto(12'd100);
    check(64'(seg), 64'(37'h0), "R2 low half zero");
    check(64'(digit), 64'(2'b01), "R7 digit 0 in phase 0");

    rst_n = 0;
    @(negedge clk);
    check(64'(digit), 64'(2'b00), "R8 mid-run reset");
    rst_n = 1;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule